// File: doc/BRIEF.md
# SD Host Command Issue Sequencer

This block runs one SD/MMC command transaction at a time. Software writes a 32-bit argument and then a command word. Setting the start flag in the command word launches the command. The sequencer decodes the control flags of the word and the transaction follows from them:

- a held wait for the data path to go idle;
- a hand-off of index and argument to a card-side command shifter;
- an optional response capture with a timeout and a CRC verdict;
- an optional automatic stop command once the data phase ends.

A command marked clock-update-only never reaches the shifter. It pulses a latch strobe toward the clock generator and retires at once.

The command shifter is modelled by two handshakes. The first is a request/acknowledge pair that sends a command. The second is a response-valid strobe that carries up to four response words and a CRC-good flag. The shifter also reports a start-bit-seen pulse. A card-clock tick input paces the response timeout. The data path reports busy and data-over. Completion and error events are single-cycle pulses.

Top module: `sdcs_seq`

## Requirements
- R1: After reset the command word reads 0, all response words read 0, the shifter request is low and no event pulses.
- R2: The command word has these fields:
  - bits 5:0: command index
  - bit 6: response expected
  - bit 7: long response
  - bit 8: check response CRC
  - bit 9: data expected
  - bit 12: auto-stop
  - bit 13: wait for the data path
  - bit 21: clock update only
  - bit 31: start

  A write with bit 31 set reads back exactly as written. Bit 31 stays 1 until the shifter acknowledges the request, and it reads 0 from the cycle after that acknowledge.
- R3: A command write made while bit 31 reads 1 is ignored. Both the readback and the index later sent are those of the earlier word.
- R4: A start with bit 21 set pulses clk_latch one cycle after the word is seen and clears bit 31 in the same step. It never raises tx_req or cmd_done.
- R5: With bit 13 set, tx_req stays low while data_busy is high. tx_req rises once data_busy falls.
- R6: With bit 6 clear, cmd_done pulses in the cycle after the acknowledge, with no timeout.
- R7: A short response (bit 6 set, bit 7 clear) loads response word 0 from rx_data[31:0]. Words 1 to 3 are unchanged. cmd_done pulses in the cycle after rx_valid.
- R8: A long response loads response word k from rx_data[32k+31:32k] for k = 0 to 3, so word 3 holds the most significant word.
- R9: resp_crc_err pulses together with the done event when bit 8 is set and rx_crc_ok is 0. It never pulses when bit 8 is clear.
- R10: If TO_CLKS (64) card ticks pass in the response wait with no rx_start, resp_timeout and cmd_done pulse together, on the 64th tick. An rx_start halts the timeout.
- R11: After a command with bits 9 and 12 set has finished, a data_over pulse makes the block send index 12 with argument 0 and expect a short response. Completion of that stop command pulses auto_done instead of cmd_done and leaves the response words unchanged. Without bit 12, data_over sends nothing.
- R12: While tx_req is high for a software command, tx_index equals bits 5:0 of the command word and tx_arg equals the argument register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word to write |
| arg_wr | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument to write |
| cmd_rdata | output | 32 | Command word readback, bit 31 is the live start flag |
| resp_words | output | 128 | Response words, word k at bits 32k+31:32k |
| tx_req | output | 1 | Request to the command shifter |
| tx_index | output | 6 | Index of the command being sent |
| tx_arg | output | 32 | Argument of the command being sent |
| tx_resp_exp | output | 1 | Sent command expects a response |
| tx_resp_long | output | 1 | Sent command expects a long response |
| tx_ack | input | 1 | Shifter has taken the command |
| rx_start | input | 1 | Response start bit seen |
| rx_valid | input | 1 | Response complete |
| rx_data | input | 128 | Response payload |
| rx_crc_ok | input | 1 | Response CRC matched |
| card_tick | input | 1 | One card clock period elapsed |
| data_busy | input | 1 | Data path still transferring |
| data_over | input | 1 | Data phase finished |
| clk_latch | output | 1 | Pulse: take new clock settings |
| cmd_done | output | 1 | Pulse: software command finished |
| auto_done | output | 1 | Pulse: automatic stop command finished |
| resp_timeout | output | 1 | Pulse: no response start in time |
| resp_crc_err | output | 1 | Pulse: response CRC failed |

## Verification
The hardest case to reach is the automatic stop command. It needs a data command with auto-stop to finish its own response first, then a data-over pulse, and then a second full handshake. The bench drives that chain directly and checks that the first response survives the stop. A second hard case is a write that lands while a command is parked behind a busy data path. The bench holds data_busy high, writes a conflicting word and then releases busy. Random short and long commands with random CRC verdicts run between the directed cases.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;
   localparam int unsigned CMD_W   = 32;
   localparam int unsigned IDX_W   = 6;
   localparam int unsigned B_RESP  = 6;
   localparam int unsigned B_LONG  = 7;
   localparam int unsigned B_CRC   = 8;
   localparam int unsigned B_DATA  = 9;
   localparam int unsigned B_ASTOP = 12;
   localparam int unsigned B_WAIT  = 13;
   localparam int unsigned B_UPCLK = 21;
   localparam int unsigned B_START = 31;

   typedef enum logic [2:0] {
      ST_IDLE, ST_HOLD, ST_SEND, ST_RESP, ST_DWAIT, ST_SSEND, ST_SRESP
   } sdcs_state_e;

   typedef struct packed {
      logic resp;
      logic long_r;
      logic crc;
      logic data;
      logic astop;
   } sdcs_ctl_t;
endpackage

// File: rtl/sdcs_cmd_reg.sv
module sdcs_cmd_reg
   import sdcs_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CMD_W-1:0] wdata,
   input  logic             clr_start,
   output logic [CMD_W-1:0] word
);
   logic [CMD_W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (wr && !q[B_START]) begin
         q <= wdata;
      end else if (clr_start) begin
         q[B_START] <= 1'b0;
      end
   end

   assign word = q;
endmodule

// File: rtl/sdcs_resp_store.sv
module sdcs_resp_store #(
   parameter int unsigned WORDS  = 4,
   parameter int unsigned WORD_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cap,
   input  logic                    cap_long,
   input  logic [WORDS*WORD_W-1:0] din,
   output logic [WORDS*WORD_W-1:0] dout
);
   genvar k;
   generate
      for (k = 0; k < WORDS; k++) begin : g_word
         logic [WORD_W-1:0] w_q;
         logic              load;
         if (k == 0) begin : g_first
            assign load = cap;
         end else begin : g_upper
            assign load = cap && cap_long;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     w_q <= '0;
            else if (load)  w_q <= din[k*WORD_W +: WORD_W];
         end
         assign dout[k*WORD_W +: WORD_W] = w_q;
      end
   endgenerate
endmodule

// File: rtl/sdcs_timer.sv
module sdcs_timer #(
   parameter int unsigned TO_CLKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic active,
   input  logic tick,
   input  logic seen_start,
   output logic expire
);
   localparam int unsigned CW = (TO_CLKS > 1) ? $clog2(TO_CLKS) : 1;
   logic [CW-1:0] cnt;
   logic          seen_q;
   logic          halted;

   assign halted = seen_q || seen_start;
   assign expire = active && tick && !halted && (cnt == CW'(TO_CLKS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         seen_q <= 1'b0;
      end else if (!active) begin
         cnt    <= '0;
         seen_q <= 1'b0;
      end else begin
         if (seen_start)         seen_q <= 1'b1;
         if (tick && !halted)    cnt    <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/sdcs_seq.sv
module sdcs_seq
   import sdcs_pkg::*;
#(
   parameter int unsigned RESP_WORDS = 4,
   parameter int unsigned TO_CLKS    = 64,
   parameter int unsigned STOP_IDX   = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cmd_wr,
   input  logic [31:0]              cmd_wdata,
   input  logic                     arg_wr,
   input  logic [31:0]              arg_wdata,
   output logic [31:0]              cmd_rdata,
   output logic [RESP_WORDS*32-1:0] resp_words,
   output logic                     tx_req,
   output logic [5:0]               tx_index,
   output logic [31:0]              tx_arg,
   output logic                     tx_resp_exp,
   output logic                     tx_resp_long,
   input  logic                     tx_ack,
   input  logic                     rx_start,
   input  logic                     rx_valid,
   input  logic [RESP_WORDS*32-1:0] rx_data,
   input  logic                     rx_crc_ok,
   input  logic                     card_tick,
   input  logic                     data_busy,
   input  logic                     data_over,
   output logic                     clk_latch,
   output logic                     cmd_done,
   output logic                     auto_done,
   output logic                     resp_timeout,
   output logic                     resp_crc_err
);
   localparam int unsigned WORD_W = 32;

   initial begin : p_param_chk
      assert (RESP_WORDS >= 1) else $error("RESP_WORDS must be at least 1");
      assert (TO_CLKS >= 2) else $error("TO_CLKS must be at least 2");
      assert (STOP_IDX < (1 << IDX_W)) else $error("STOP_IDX exceeds the index field");
   end

   sdcs_state_e st, nxt;
   sdcs_ctl_t   cur;
   logic [CMD_W-1:0] cmd_q;
   logic [31:0]      arg_q;
   logic start, clr_start, latch_cur, cap, expire, t_active;
   logic lat_n, done_n, adone_n, to_n, crc_n;
   sdcs_state_e main_next;

   sdcs_cmd_reg u_cmd (
      .clk(clk), .rst_n(rst_n), .wr(cmd_wr), .wdata(cmd_wdata),
      .clr_start(clr_start), .word(cmd_q)
   );

   sdcs_resp_store #(.WORDS(RESP_WORDS), .WORD_W(WORD_W)) u_resp (
      .clk(clk), .rst_n(rst_n), .cap(cap), .cap_long(cur.long_r),
      .din(rx_data), .dout(resp_words)
   );

   assign t_active = (st == ST_RESP) || (st == ST_SRESP);

   sdcs_timer #(.TO_CLKS(TO_CLKS)) u_tmr (
      .clk(clk), .rst_n(rst_n), .active(t_active), .tick(card_tick),
      .seen_start(rx_start), .expire(expire)
   );

   assign start     = cmd_q[B_START];
   assign cmd_rdata = cmd_q;
   assign main_next = (cur.data && cur.astop) ? ST_DWAIT : ST_IDLE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arg_q <= '0;
      else if (arg_wr) arg_q <= arg_wdata;
   end

   always_comb begin
      nxt       = st;
      clr_start = 1'b0;
      latch_cur = 1'b0;
      cap       = 1'b0;
      lat_n     = 1'b0;
      done_n    = 1'b0;
      adone_n   = 1'b0;
      to_n      = 1'b0;
      crc_n     = 1'b0;
      unique case (st)
         ST_IDLE: begin
            if (start) begin
               if (cmd_q[B_UPCLK]) begin
                  lat_n     = 1'b1;
                  clr_start = 1'b1;
               end else begin
                  latch_cur = 1'b1;
                  nxt = (cmd_q[B_WAIT] && data_busy) ? ST_HOLD : ST_SEND;
               end
            end
         end
         ST_HOLD: if (!data_busy) nxt = ST_SEND;
         ST_SEND: begin
            if (tx_ack) begin
               clr_start = 1'b1;
               if (cur.resp) begin
                  nxt = ST_RESP;
               end else begin
                  done_n = 1'b1;
                  nxt    = main_next;
               end
            end
         end
         ST_RESP: begin
            if (rx_valid) begin
               cap    = 1'b1;
               crc_n  = cur.crc && !rx_crc_ok;
               done_n = 1'b1;
               nxt    = main_next;
            end else if (expire) begin
               to_n   = 1'b1;
               done_n = 1'b1;
               nxt    = main_next;
            end
         end
         ST_DWAIT: if (data_over) nxt = ST_SSEND;
         ST_SSEND: if (tx_ack) nxt = ST_SRESP;
         ST_SRESP: begin
            if (rx_valid) begin
               crc_n   = !rx_crc_ok;
               adone_n = 1'b1;
               nxt     = ST_IDLE;
            end else if (expire) begin
               to_n    = 1'b1;
               adone_n = 1'b1;
               nxt     = ST_IDLE;
            end
         end
         default: nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st           <= ST_IDLE;
         cur          <= '0;
         clk_latch    <= 1'b0;
         cmd_done     <= 1'b0;
         auto_done    <= 1'b0;
         resp_timeout <= 1'b0;
         resp_crc_err <= 1'b0;
      end else begin
         st           <= nxt;
         clk_latch    <= lat_n;
         cmd_done     <= done_n;
         auto_done    <= adone_n;
         resp_timeout <= to_n;
         resp_crc_err <= crc_n;
         if (latch_cur) begin
            cur.resp   <= cmd_q[B_RESP];
            cur.long_r <= cmd_q[B_RESP] && cmd_q[B_LONG];
            cur.crc    <= cmd_q[B_CRC];
            cur.data   <= cmd_q[B_DATA];
            cur.astop  <= cmd_q[B_ASTOP];
         end
      end
   end

   assign tx_req       = (st == ST_SEND) || (st == ST_SSEND);
   assign tx_index     = (st == ST_SSEND) ? IDX_W'(STOP_IDX) : cmd_q[IDX_W-1:0];
   assign tx_arg       = (st == ST_SSEND) ? '0 : arg_q;
   assign tx_resp_exp  = (st == ST_SSEND) ? 1'b1 : cur.resp;
   assign tx_resp_long = (st == ST_SEND) && cur.long_r;
endmodule

// File: rtl/sdcs_seq_chk.sv
module sdcs_seq_chk
   import sdcs_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] cmd_rdata,
   input logic        clr_start,
   input logic        tx_req,
   input logic        tx_ack,
   input logic        clk_latch,
   input logic        cmd_done,
   input logic        auto_done,
   input logic        resp_timeout,
   input logic        resp_crc_err,
   input logic        data_busy,
   input logic [2:0]  st,
   input logic        cur_resp
);
   // R3: pending word cannot be changed by writes
   a_r3_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_rdata[31] && !clr_start) |=> $stable(cmd_rdata));

   // R2: start clears once taken
   a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      clr_start |=> !cmd_rdata[31]);

   // R4: clock update makes no bus traffic
   a_r4_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      clk_latch |-> (!tx_req && !cmd_done));

   // R5: held behind busy data path
   a_r5_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_HOLD && data_busy) |=> !tx_req);

   // R6: no response means done right after accept
   a_r6_noresp_done: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SEND && tx_ack && !cur_resp) |=> (cmd_done && !resp_timeout));

   // R9: CRC error comes with a done event
   a_r9_crc_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      resp_crc_err |-> (cmd_done || auto_done));

   // R10: timeout comes with a done event
   a_r10_to_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      resp_timeout |-> (cmd_done || auto_done));

   // R11: stop completion is distinct from command completion
   a_r11_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_done && auto_done));
endmodule

bind sdcs_seq sdcs_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_rdata(cmd_rdata), .clr_start(clr_start),
   .tx_req(tx_req), .tx_ack(tx_ack), .clk_latch(clk_latch), .cmd_done(cmd_done),
   .auto_done(auto_done), .resp_timeout(resp_timeout), .resp_crc_err(resp_crc_err),
   .data_busy(data_busy), .st(st), .cur_resp(cur.resp)
);

// File: tb/sdcs_seq_tb.sv
module sdcs_seq_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_wr = 0, arg_wr = 0, tx_ack = 0, rx_start = 0, rx_valid = 0;
   logic rx_crc_ok = 1, card_tick = 0, data_busy = 0, data_over = 0;
   logic [31:0] cmd_wdata = 0, arg_wdata = 0;
   logic [127:0] rx_data = 0;
   logic [31:0] cmd_rdata, tx_arg;
   logic [127:0] resp_words;
   logic tx_req, tx_resp_exp, tx_resp_long;
   logic [5:0] tx_index;
   logic clk_latch, cmd_done, auto_done, resp_timeout, resp_crc_err;

   int total = 0, bad = 0;
   bit finished = 0;
   logic [31:0] m_resp [4];

   localparam logic [31:0] F_RESP = 32'h40, F_LONG = 32'h80, F_CRC = 32'h100,
      F_DATA = 32'h200, F_ASTOP = 32'h1000, F_WAIT = 32'h2000,
      F_UPCLK = 32'h20_0000, F_START = 32'h8000_0000;

   always #2 clk = ~clk;

   sdcs_seq u_dut (.*);

   task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(int k, logic lng, logic [127:0] d, logic [31:0] old);
      if (k == 0 || lng) return d[k*32 +: 32];
      return old;
   endfunction

   function automatic logic exp_crc(logic chk, logic ok);
      return chk && !ok;
   endfunction

   task automatic wr_cmd(input logic [31:0] w);
      @(negedge clk); cmd_wr = 1; cmd_wdata = w;
      @(negedge clk); cmd_wr = 0;
   endtask

   task automatic wr_arg(input logic [31:0] a);
      @(negedge clk); arg_wr = 1; arg_wdata = a;
      @(negedge clk); arg_wr = 0;
   endtask

   task automatic wait_req();
      int n = 0;
      while (!tx_req && n < 300) begin @(negedge clk); n++; end
   endtask

   task automatic ack();
      tx_ack = 1; @(negedge clk); tx_ack = 0;
   endtask

   task automatic give_resp(input logic [127:0] d, input logic ok);
      rx_valid = 1; rx_data = d; rx_crc_ok = ok;
      @(negedge clk); rx_valid = 0; rx_crc_ok = 1;
   endtask

   task automatic check_resp(string tag);
      for (int k = 0; k < 4; k++) check(tag, resp_words[k*32 +: 32], m_resp[k]);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] w, a;
      logic [127:0] d;
      logic lng, chk, ok;
      int n;
      bit saw;
      void'($urandom(32'd4242));
      for (int k = 0; k < 4; k++) m_resp[k] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      check("R1 cmd", cmd_rdata, 0);
      check("R1 resp", resp_words, 0);
      check("R1 events", {tx_req, clk_latch, cmd_done, auto_done, resp_timeout, resp_crc_err}, 0);

      // R2 R7 R12 directed short response
      wr_arg(32'hCAFE_0011);
      w = F_START | F_RESP | F_CRC | 32'd17;
      wr_cmd(w);
      check("R2 readback", cmd_rdata, w);
      wait_req();
      check("R12 index", tx_index, 17);
      check("R12 arg", tx_arg, 32'hCAFE_0011);
      check("R2 start held", cmd_rdata[31], 1);
      ack();
      check("R2 start cleared", cmd_rdata[31], 0);
      d = {32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'hA5A5_0001};
      give_resp(d, 1);
      for (int k = 0; k < 4; k++) m_resp[k] = exp_word(k, 0, d, m_resp[k]);
      check("R7 done", {cmd_done, resp_crc_err, resp_timeout}, 3'b100);
      check_resp("R7 short words");

      // R7 R8 R9 random mix
      for (int i = 0; i < 10; i++) begin
         lng = 1'($urandom % 2); chk = 1'($urandom % 2); ok = 1'($urandom % 2);
         a = $urandom;
         d = {$urandom, $urandom, $urandom, $urandom};
         wr_arg(a);
         w = F_START | F_RESP | (lng ? F_LONG : 0) | (chk ? F_CRC : 0) | 32'($urandom % 64);
         wr_cmd(w);
         wait_req();
         check("R12 rand index", tx_index, w[5:0]);
         check("R12 rand arg", tx_arg, a);
         check("R8 long flag", tx_resp_long, lng);
         ack();
         give_resp(d, ok);
         for (int k = 0; k < 4; k++) m_resp[k] = exp_word(k, lng, d, m_resp[k]);
         check("R9 crc verdict", resp_crc_err, exp_crc(chk, ok));
         check("R8 done", cmd_done, 1);
         check_resp(lng ? "R8 long words" : "R7 short words");
      end

      // R6 no response
      wr_cmd(F_START | 32'd0);
      wait_req();
      check("R6 no resp exp", tx_resp_exp, 0);
      ack();
      check("R6 done", {cmd_done, resp_timeout}, 2'b10);
      @(negedge clk);
      check("R6 single pulse", cmd_done, 0);

      // R10 timeout on exact tick
      card_tick = 1;
      wr_cmd(F_START | F_RESP | 32'd2);
      wait_req(); ack();
      n = 0;
      while (!cmd_done && n < 200) begin @(negedge clk); n++; end
      check("R10 tick count", n, 64);
      check("R10 timeout flag", resp_timeout, 1);
      check_resp("R10 words kept");
      // R10 start bit halts the timer
      wr_cmd(F_START | F_RESP | 32'd3);
      wait_req(); ack();
      repeat (10) @(negedge clk);
      rx_start = 1; @(negedge clk); rx_start = 0;
      saw = 0;
      for (int i = 0; i < 100; i++) begin @(negedge clk); if (cmd_done || resp_timeout) saw = 1; end
      check("R10 halted", saw, 0);
      d = {4{32'h0BAD_F00D}};
      give_resp(d, 1);
      m_resp[0] = d[31:0];
      check("R10 late resp", {cmd_done, resp_timeout}, 2'b10);
      card_tick = 0;

      // R4 clock update only
      wr_cmd(F_START | F_UPCLK | F_RESP | 32'd7);
      @(negedge clk);
      check("R4 latch", {clk_latch, tx_req, cmd_done}, 3'b100);
      check("R4 start cleared", cmd_rdata[31], 0);
      saw = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (tx_req || cmd_done) saw = 1; end
      check("R4 no traffic", saw, 0);

      // R5 wait for data path, R3 ignored write
      data_busy = 1;
      w = F_START | F_WAIT | 32'd5;
      wr_cmd(w);
      saw = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (tx_req) saw = 1; end
      check("R5 held", saw, 0);
      wr_cmd(F_START | 32'd9);
      check("R3 word kept", cmd_rdata, w);
      data_busy = 0;
      wait_req();
      check("R5 released", tx_req, 1);
      check("R3 index kept", tx_index, 5);
      ack();
      check("R3 done", cmd_done, 1);

      // R11 data without auto-stop sends nothing
      wr_cmd(F_START | F_DATA | 32'd24);
      wait_req(); ack();
      @(negedge clk);
      data_over = 1; @(negedge clk); data_over = 0;
      saw = 0;
      for (int i = 0; i < 10; i++) begin @(negedge clk); if (tx_req) saw = 1; end
      check("R11 no stop", saw, 0);

      // R11 auto-stop
      wr_arg(32'h0000_1234);
      wr_cmd(F_START | F_DATA | F_ASTOP | F_RESP | 32'd18);
      wait_req(); ack();
      d = {96'h0, 32'h600D_0018};
      give_resp(d, 1);
      m_resp[0] = d[31:0];
      check("R11 main done", {cmd_done, auto_done}, 2'b10);
      saw = 0;
      for (int i = 0; i < 8; i++) begin @(negedge clk); if (tx_req) saw = 1; end
      check("R11 waits data", saw, 0);
      data_over = 1; @(negedge clk); data_over = 0;
      wait_req();
      check("R11 stop index", tx_index, 12);
      check("R11 stop arg", tx_arg, 0);
      check("R11 stop resp", {tx_resp_exp, tx_resp_long}, 2'b10);
      ack();
      give_resp({4{32'hDEAD_BEEF}}, 1);
      check("R11 auto done", {auto_done, cmd_done}, 2'b10);
      check_resp("R11 words kept");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule